// File: doc/BRIEF.md
# Video Line Count Change Detector

This block sits beside one receive port of a video link. It counts the long packets that arrive between a start-of-frame strobe and the end-of-frame strobe that closes that frame. Each long packet counts as one video line. When a frame closes, its total is compared with the total of the frame before. If the two differ, the block emits a one-cycle change pulse and sets a sticky status bit that an interrupt aggregator can read and clear.

The block also copes with broken frame framing. A start-of-frame that arrives while a frame is still open throws away the partial frame. An end-of-frame with no open frame does nothing. Dropping the enable input abandons the open frame and forgets the reference total. Packet parsing, CRC checks, line buffering and the video data path are handled elsewhere. This block only counts and compares.

Top module: `line_count_monitor`

## Requirements
- R1: A long packet (`pktValid`=1, `pktLong`=1) inside an open frame adds exactly one to the frame's line total. A long packet in the same cycle as the start-of-frame strobe counts as that frame's first line. A long packet in the same cycle as the end-of-frame strobe counts toward the frame it closes.
- R2: A short packet (`pktValid`=1, `pktLong`=0) never changes the line total.
- R3: A long packet that arrives while no frame is open is ignored.
- R4: `lastCount` is 0 after reset. One cycle after an end-of-frame closes an open frame, `lastCount` shows that frame's total. It changes at no other time.
- R5: When a closing frame's total differs from the stored `lastCount`, and a reference exists, `changePulse` is high for exactly the one cycle after the end-of-frame. An equal total gives no pulse.
- R6: The first frame that closes after reset, or after `enable` returns high, only sets the reference. It raises no change pulse.
- R7: A start-of-frame while a frame is open restarts counting from zero. The partial frame is discarded without any comparison, and `lastCount` is left unchanged.
- R8: The line total saturates at 2^CNT_W-1 and does not wrap. Two frames that both saturate compare equal.
- R9: `stickyStat` is set in the same cycle that `changePulse` rises. A one-cycle `rdClr` clears it on the next edge. If a change event occurs in the same cycle as `rdClr`, the bit stays set.
- R10: An end-of-frame with no open frame is ignored. When start-of-frame and end-of-frame arrive in the same cycle, start-of-frame wins and a new frame opens.
- R11: While `enable` is low, no packet or strobe has any effect. The open frame is abandoned and the reference is forgotten. `lastCount` and `stickyStat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable; while low, the open frame and the reference are dropped |
| sofStb | input | 1 | Start-of-frame strobe |
| eofStb | input | 1 | End-of-frame strobe |
| pktValid | input | 1 | A packet header was received this cycle |
| pktLong | input | 1 | 1 = long packet, 0 = short packet; only meaningful with `pktValid` |
| rdClr | input | 1 | One-cycle read-clear strobe for `stickyStat` |
| lastCount | output | CNT_W | Line total of the last completed frame |
| changePulse | output | 1 | One-cycle pulse when a frame's total differs from the previous frame's |
| stickyStat | output | 1 | Sticky change flag for the interrupt aggregator |

## Verification
The bench builds the block with CNT_W = 4. This makes the saturation limit 15 lines, so a frame of 20 long packets drives the counter well past its ceiling in a few dozen cycles. It also means two saturated frames in a row can be shown to compare equal. At this width every frame-boundary corner is short, so one run can cover restarts, stray end-of-frame strobes, a same-cycle start and end, and an enable drop in the middle of a frame.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  // Strobes from the framing control to the counting datapath.
  typedef struct packed {
    logic startFrame;  // open a new frame (count restarts)
    logic countLine;   // a long packet belongs to the current/new frame
    logic closeFrame;  // latch the total and compare
    logic flush;       // enable low: drop everything in flight
  } lcStrobe_t;
endpackage

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sofStb,
  input  logic       eofStb,
  input  logic       pktValid,
  input  logic       pktLong,
  input  logic       rdClr,
  input  logic       countDiffers,
  output lcStrobe_t  strobe,
  output logic       changePulse,
  output logic       stickyStat
);
  logic inFrame;
  logic refValid;
  logic changeNow;

  always_comb begin
    strobe.flush      = ~enable;
    strobe.startFrame = enable & sofStb;
    strobe.countLine  = enable & pktValid & pktLong & (inFrame | sofStb);
    strobe.closeFrame = enable & eofStb & ~sofStb & inFrame;
  end

  assign changeNow = strobe.closeFrame & refValid & countDiffers;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame     <= 1'b0;
      refValid    <= 1'b0;
      changePulse <= 1'b0;
      stickyStat  <= 1'b0;
    end else begin
      if (strobe.flush) begin
        inFrame  <= 1'b0;
        refValid <= 1'b0;
      end else if (strobe.startFrame) begin
        inFrame <= 1'b1;
      end else if (strobe.closeFrame) begin
        inFrame  <= 1'b0;
        refValid <= 1'b1;
      end
      changePulse <= changeNow;
      stickyStat  <= changeNow | (stickyStat & ~rdClr);
    end
  end
endmodule

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  lcStrobe_t        strobe,
  output logic [CNT_W-1:0] lastCount,
  output logic             countDiffers
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] frameTotal;

  always_comb begin
    baseCnt = strobe.startFrame ? '0 : lineCnt;
    if (strobe.countLine && (baseCnt != CNT_MAX))
      frameTotal = baseCnt + CNT_W'(1);
    else
      frameTotal = baseCnt;
  end

  assign countDiffers = (frameTotal != lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt   <= '0;
      lastCount <= '0;
    end else if (strobe.flush) begin
      lineCnt <= '0;
    end else if (strobe.closeFrame) begin
      lineCnt   <= '0;
      lastCount <= frameTotal;
    end else if (strobe.startFrame || strobe.countLine) begin
      lineCnt <= frameTotal;
    end
  end
endmodule

// File: rtl/line_count_monitor.sv
module line_count_monitor
  import lcd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sofStb,
  input  logic             eofStb,
  input  logic             pktValid,
  input  logic             pktLong,
  input  logic             rdClr,
  output logic [CNT_W-1:0] lastCount,
  output logic             changePulse,
  output logic             stickyStat
);
  lcStrobe_t strobe;
  logic      countDiffers;

  lcd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .sofStb(sofStb),
    .eofStb(eofStb), .pktValid(pktValid), .pktLong(pktLong),
    .rdClr(rdClr), .countDiffers(countDiffers), .strobe(strobe),
    .changePulse(changePulse), .stickyStat(stickyStat)
  );

  lcd_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lastCount(lastCount), .countDiffers(countDiffers)
  );
endmodule

// File: rtl/line_count_monitor_chk.sv
module line_count_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             eofStb,
  input logic             rdClr,
  input logic [CNT_W-1:0] lastCount,
  input logic             changePulse,
  input logic             stickyStat
);
  // R5: a change pulse only follows an enabled end-of-frame
  a_r5_pulse_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    changePulse |-> ($past(eofStb) && $past(enable)));

  // R5: the pulse lasts a single cycle (an end-of-frame must recur for another)
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (changePulse && !eofStb) |=> !changePulse);

  // R4: the stored total moves only after an enabled end-of-frame
  a_r4_last_only_at_eof: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastCount) |-> ($past(eofStb) && $past(enable)));

  // R9: the sticky bit rises only together with a change pulse
  a_r9_sticky_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyStat) |-> changePulse);

  // R9: a pulse always leaves the sticky bit set
  a_r9_pulse_sets: assert property (@(posedge clk) disable iff (!rstN)
    changePulse |-> stickyStat);

  // R9: after a read-clear the bit equals whether an event coincided
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    rdClr |=> (stickyStat == changePulse));

  // R11: no pulse is produced while disabled
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !changePulse);
endmodule

bind line_count_monitor line_count_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .eofStb(eofStb), .rdClr(rdClr),
  .lastCount(lastCount), .changePulse(changePulse), .stickyStat(stickyStat)
);

// File: tb/line_count_monitor_tb_top.sv
`timescale 1ns/1ps
module line_count_monitor_tb_top;
  localparam int CW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, sofStb = 1'b0, eofStb = 1'b0;
  logic pktValid = 1'b0, pktLong = 1'b0, rdClr = 1'b0;
  logic [CW-1:0] lastCount;
  logic changePulse, stickyStat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_count_monitor #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .sofStb(sofStb),
    .eofStb(eofStb), .pktValid(pktValid), .pktLong(pktLong), .rdClr(rdClr),
    .lastCount(lastCount), .changePulse(changePulse), .stickyStat(stickyStat)
  );

  // behavioural reference model
  int  mCnt = 0, mLast = 0;
  bit  mIn = 0, mRefOk = 0, mPulse = 0, mSticky = 0;
  always @(posedge clk) begin
    bit ev;
    ev = 0;
    if (!rstN) begin
      mIn = 0; mCnt = 0; mRefOk = 0; mLast = 0; mPulse = 0; mSticky = 0;
    end else begin
      if (!enable) begin
        mIn = 0; mCnt = 0; mRefOk = 0;
      end else if (sofStb) begin
        mIn = 1; mCnt = (pktValid && pktLong) ? 1 : 0;
      end else if (mIn) begin
        if (pktValid && pktLong && mCnt < MAXC) mCnt++;
        if (eofStb) begin
          ev = mRefOk && (mCnt != mLast);
          mLast = mCnt; mRefOk = 1; mIn = 0; mCnt = 0;
        end
      end
      mPulse  = ev;
      mSticky = ev || (mSticky && !rdClr);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 model lastCount", int'(lastCount), mLast);
      chk("R5 model changePulse", int'(changePulse), int'(mPulse));
      chk("R9 model stickyStat", int'(stickyStat), int'(mSticky));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // one cycle with the given inputs; returns at the following negedge
  task automatic cyc(bit s, bit e, bit pv, bit pl, bit rc = 0);
    sofStb = s; eofStb = e; pktValid = pv; pktLong = pl; rdClr = rc;
    @(negedge clk);
    sofStb = 0; eofStb = 0; pktValid = 0; pktLong = 0; rdClr = 0;
  endtask

  task automatic longs(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 1);
  endtask

  task automatic frame(int nLong, int nShort);
    cyc(1, 0, 0, 0);
    for (int i = 0; i < nShort; i++) cyc(0, 0, 1, 0);
    longs(nLong);
    cyc(0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset lastCount", int'(lastCount), 0);
    chk("R9 reset sticky", int'(stickyStat), 0);
    rstN = 1; enable = 1;
    @(negedge clk);

    frame(3, 2);
    chk("R1 R2 first frame total", int'(lastCount), 3);
    chk("R6 no pulse on first frame", int'(changePulse), 0);

    frame(3, 0);
    chk("R5 equal totals no pulse", int'(changePulse), 0);

    frame(5, 1);
    chk("R4 lastCount updated", int'(lastCount), 5);
    chk("R5 pulse on change", int'(changePulse), 1);
    chk("R9 sticky set", int'(stickyStat), 1);
    cyc(0, 0, 0, 0);
    chk("R5 pulse one cycle", int'(changePulse), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R9 sticky cleared", int'(stickyStat), 0);

    longs(4);
    frame(5, 0);
    chk("R3 outside longs ignored", int'(lastCount), 5);
    chk("R3 no pulse", int'(changePulse), 0);

    cyc(0, 1, 0, 0);
    chk("R10 stray eof ignored", int'(lastCount), 5);
    chk("R10 stray eof no pulse", int'(changePulse), 0);

    cyc(1, 0, 0, 0); longs(2);
    cyc(1, 0, 0, 0);
    chk("R7 restart leaves lastCount", int'(lastCount), 5);
    chk("R7 restart no pulse", int'(changePulse), 0);
    longs(5); cyc(0, 1, 0, 0);
    chk("R7 partial discarded", int'(lastCount), 5);
    chk("R7 no compare", int'(changePulse), 0);

    cyc(1, 0, 1, 1); longs(1); cyc(0, 1, 1, 1);
    chk("R1 sof and eof cycle packets count", int'(lastCount), 3);
    chk("R5 pulse 5 to 3", int'(changePulse), 1);

    cyc(1, 0, 0, 0); longs(4); cyc(0, 1, 0, 0, 1);
    chk("R9 event beats clear", int'(stickyStat), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R9 clear after", int'(stickyStat), 0);

    frame(20, 0);
    chk("R8 saturation", int'(lastCount), MAXC);
    chk("R8 pulse on change", int'(changePulse), 1);
    frame(MAXC, 0);
    chk("R8 saturated equal", int'(changePulse), 0);

    cyc(1, 0, 0, 0); longs(2);
    enable = 0; cyc(0, 0, 1, 1); cyc(0, 1, 0, 0);
    chk("R11 disabled no effect", int'(lastCount), MAXC);
    enable = 1;
    longs(3); cyc(0, 1, 0, 0);
    chk("R11 frame abandoned", int'(lastCount), MAXC);
    frame(2, 0);
    chk("R11 R6 new reference", int'(lastCount), 2);
    chk("R6 no pulse after enable", int'(changePulse), 0);

    cyc(1, 1, 0, 0); longs(1); cyc(0, 1, 0, 0);
    chk("R10 sof wins over eof", int'(lastCount), 1);
    chk("R10 pulse 2 to 1", int'(changePulse), 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule